// File: doc/BRIEF.md
# DDR Command Bus Timing Monitor

This block watches the command bus of a registered DDR SDRAM module once per clock. It decodes each command, keeps track of which of the four internal banks is open, and records how many cycles have passed since the last write, read, burst stop, mode register set and self-refresh exit. It then checks every new command against the minimum spacings that apply to it.

Each timing rule has its own flag bit. A flag is registered and is high for exactly the one cycle after the command that broke its rule. A separate protocol-error flag marks a read or write to a bank that is closed, or an activate to a bank that is already open. The minimum spacings come from two configuration inputs, burst length and CAS latency. The monitor drives nothing onto the bus and stores no data.

Top module: `ddr_cmd_timing_mon`

## Requirements
- R1: A command is taken only when `sel_n` is low. The code `{rstb_n, cstb_n, wen_n}` is 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode-register set, 110 burst stop and 111 no-op. While `sel_n` is high the inputs raise no flag, but every elapsed-cycle count keeps advancing.
- R2: The bank index is `{bsel_hi, bsel_lo}`. The four values address four independent banks, so the state of one bank never affects a command to another.
- R3: A precharge with `ap_bit` high closes all banks, and with `ap_bit` low it closes only the addressed bank. A read or write with `ap_bit` high closes its bank (auto-precharge).
- R4: `proto_err` is raised for a read or write to a closed bank and for an activate to an open bank.
- R5: `cfg_bl` selects the burst length: 0 = 2, 1 = 4, 2 or 3 = 8. Flag bit 0 is raised for a precharge that reaches a bank fewer than 3 + BL/2 cycles after a write to that bank.
- R6: Flag bit 1 is raised for a precharge that reaches a bank fewer than BL/2 cycles after a read from that bank.
- R7: Flag bit 2 is raised for a read issued fewer than 2 + BL/2 cycles after any write.
- R8: `cfg_cl_half` = 0 selects CAS latency 3 and 1 selects 3.5. Flag bit 3 is raised for a write issued fewer than 2 + BL/2 + `cfg_cl_half` cycles after any read.
- R9: Flag bit 4 is raised for a write issued fewer than 2 + `cfg_cl_half` cycles after a burst stop.
- R10: Flag bit 5 is raised for an activate or a mode-register set issued fewer than 2 cycles after a mode-register set.
- R11: A refresh with `clk_en` low enters self-refresh. The first cycle with `clk_en` high exits it. After that exit, flag bit 6 is raised for a command other than read issued fewer than 10 cycles later, and flag bit 7 for a read issued fewer than 200 cycles later.
- R12: Flag bit 8 is raised when `clk_en` changes level one cycle after its previous change. Flag bit 9 is raised for a command issued in the first cycle that `clk_en` is high after being low.
- R13: All flags appear in the cycle after the offending command and last one cycle. A synchronous active-high `rst` clears the flags and closes all banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock, one command slot per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low command select |
| rstb_n | input | 1 | Active-low row strobe |
| cstb_n | input | 1 | Active-low column strobe |
| wen_n | input | 1 | Active-low write enable |
| clk_en | input | 1 | Clock enable (power-down and self-refresh control) |
| bsel_hi | input | 1 | Bank select, high bit of the bank index |
| bsel_lo | input | 1 | Bank select, low bit of the bank index |
| ap_bit | input | 1 | All-bank precharge / auto-precharge select |
| cfg_bl | input | 2 | Burst length code |
| cfg_cl_half | input | 1 | CAS latency 3.5 when high, 3 when low |
| viol | output | 10 | Registered timing-violation flags, one bit per rule |
| proto_err | output | 1 | Registered bank-state protocol error |

## Verification
The assertions check every cycle that the flags are clear after reset, that a deselected cycle raises no command-related flag, that an all-bank precharge leaves every bank closed, that entering self-refresh is recorded, that the elapsed-cycle counters restart and advance by one, and that the read-to-precharge flag never fires with a burst length of 2. The exact boundary of each minimum spacing, for every burst length and CAS latency, can only be shown by the bench scenarios, which issue commands one cycle inside and exactly on each limit. The same holds for the 200-cycle read window after self-refresh and for the clock-enable pulse and power-down exit cases.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;

    localparam int AGE_W       = 8;
    localparam int BANK_W      = 2;
    localparam int NUM_BANKS   = 1 << BANK_W;
    localparam int NUM_RULES   = 10;
    localparam int NUM_CMD_RULES = 8;

    localparam int RULE_WR2PRE = 0;
    localparam int RULE_RD2PRE = 1;
    localparam int RULE_WR2RD  = 2;
    localparam int RULE_RD2WR  = 3;
    localparam int RULE_BST2WR = 4;
    localparam int RULE_MRS    = 5;
    localparam int RULE_SRX_CMD = 6;
    localparam int RULE_SRX_RD = 7;
    localparam int RULE_CKE_HOLD = 8;
    localparam int RULE_PD_EXIT = 9;

    // Indices of the bank-independent history counters
    localparam int HIST_WR  = 0;
    localparam int HIST_RD  = 1;
    localparam int HIST_BST = 2;
    localparam int HIST_MRS = 3;
    localparam int NUM_HIST = 4;

    typedef logic [AGE_W-1:0] age_t;

    typedef enum logic [2:0] {
        CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_MRS, CMD_BST
    } ddr_cmd_e;

    typedef struct packed {
        ddr_cmd_e           op;
        logic [BANK_W-1:0]  bank;
        logic               ap;
        logic               valid;
        logic               sr_entry;
    } cmd_t;

    function automatic age_t half_burst(input logic [1:0] bl_code);
        case (bl_code)
            2'd0:    return age_t'(1);
            2'd1:    return age_t'(2);
            default: return age_t'(4);
        endcase
    endfunction

    function automatic age_t min_wr2pre(input logic [1:0] bl_code);
        return age_t'(3) + half_burst(bl_code);
    endfunction

    function automatic age_t min_wr2rd(input logic [1:0] bl_code);
        return age_t'(2) + half_burst(bl_code);
    endfunction

    function automatic age_t min_rd2wr(input logic [1:0] bl_code, input logic cl_half);
        return age_t'(2) + half_burst(bl_code) + age_t'(cl_half);
    endfunction

    function automatic age_t min_bst2wr(input logic cl_half);
        return age_t'(2) + age_t'(cl_half);
    endfunction

endpackage

// File: rtl/ddr_age_ctr.sv
module ddr_age_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    output logic [W-1:0] age
);
    localparam logic [W-1:0] SAT = '1;

    // Saturated means "long ago": no spacing rule can fire against it.
    always_ff @(posedge clk) begin
        if (rst)              age <= SAT;
        else if (load)        age <= W'(1);
        else if (age != SAT)  age <= age + W'(1);
    end

    // R13
    age_restart_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (age == W'(1)));

    // R1
    age_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && age != SAT) |=> (age == $past(age) + W'(1)));

endmodule

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
    import ddr_mon_pkg::*;
(
    input  logic sel_n,
    input  logic rstb_n,
    input  logic cstb_n,
    input  logic wen_n,
    input  logic clk_en,
    input  logic bsel_hi,
    input  logic bsel_lo,
    input  logic ap_bit,
    output cmd_t cmd
);
    ddr_cmd_e raw_op;

    always_comb begin
        case ({rstb_n, cstb_n, wen_n})
            3'b011:  raw_op = CMD_ACT;
            3'b101:  raw_op = CMD_RD;
            3'b100:  raw_op = CMD_WR;
            3'b010:  raw_op = CMD_PRE;
            3'b001:  raw_op = CMD_REF;
            3'b000:  raw_op = CMD_MRS;
            3'b110:  raw_op = CMD_BST;
            default: raw_op = CMD_NOP;
        endcase
    end

    always_comb begin
        cmd.op       = sel_n ? CMD_NOP : raw_op;
        cmd.bank     = {bsel_hi, bsel_lo};
        cmd.ap       = ap_bit;
        cmd.valid    = !sel_n && clk_en && (raw_op != CMD_NOP);
        cmd.sr_entry = !sel_n && !clk_en && (raw_op == CMD_REF);
    end

endmodule

// File: rtl/ddr_bank_track.sv
module ddr_bank_track
    import ddr_mon_pkg::*;
#(
    parameter int NB = NUM_BANKS
) (
    input  logic          clk,
    input  logic          rst,
    input  cmd_t          cmd,
    output logic [NB-1:0] bank_open,
    output age_t          wr_age [NB],
    output age_t          rd_age [NB]
);
    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic hit;
        logic open_r;
        logic closes;

        assign hit    = cmd.valid && (cmd.bank == BANK_W'(b));
        assign closes = (cmd.valid && cmd.op == CMD_PRE && (cmd.ap || hit))
                     || (hit && cmd.ap && (cmd.op == CMD_RD || cmd.op == CMD_WR));

        ddr_age_ctr #(.W(AGE_W)) u_wr_age (
            .clk (clk),
            .rst (rst),
            .load(hit && cmd.op == CMD_WR),
            .age (wr_age[b])
        );

        ddr_age_ctr #(.W(AGE_W)) u_rd_age (
            .clk (clk),
            .rst (rst),
            .load(hit && cmd.op == CMD_RD),
            .age (rd_age[b])
        );

        always_ff @(posedge clk) begin
            if (rst)                          open_r <= 1'b0;
            else if (closes)                  open_r <= 1'b0;
            else if (hit && cmd.op == CMD_ACT) open_r <= 1'b1;
        end

        assign bank_open[b] = open_r;
    end

    // R3
    pre_all_closes_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.valid && cmd.op == CMD_PRE && cmd.ap) |=> (bank_open == '0));

endmodule

// File: rtl/ddr_pwr_track.sv
module ddr_pwr_track
    import ddr_mon_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clk_en,
    input  logic sr_entry,
    output logic cke_short,
    output logic pd_exit,
    output age_t srx_age
);
    logic cke_d1;
    logic cke_d2;
    logic sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cke_d1 <= 1'b1;
            cke_d2 <= 1'b1;
            sr_q   <= 1'b0;
        end else begin
            cke_d1 <= clk_en;
            cke_d2 <= cke_d1;
            if (sr_entry)    sr_q <= 1'b1;
            else if (clk_en) sr_q <= 1'b0;
        end
    end

    assign cke_short = (clk_en != cke_d1) && (cke_d1 != cke_d2);
    assign pd_exit   = clk_en && !cke_d1;

    ddr_age_ctr #(.W(AGE_W)) u_srx_age (
        .clk (clk),
        .rst (rst),
        .load(sr_q && clk_en),
        .age (srx_age)
    );

    // R11
    sr_entry_seen_chk: assert property (@(posedge clk) disable iff (rst)
        sr_entry |=> sr_q);

endmodule

// File: rtl/ddr_cmd_timing_mon.sv
module ddr_cmd_timing_mon
    import ddr_mon_pkg::*;
#(
    parameter int SRX_CMD_MIN = 10,
    parameter int SRX_RD_MIN  = 200,
    parameter int MRS_MIN     = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel_n,
    input  logic                 rstb_n,
    input  logic                 cstb_n,
    input  logic                 wen_n,
    input  logic                 clk_en,
    input  logic                 bsel_hi,
    input  logic                 bsel_lo,
    input  logic                 ap_bit,
    input  logic [1:0]           cfg_bl,
    input  logic                 cfg_cl_half,
    output logic [NUM_RULES-1:0] viol,
    output logic                 proto_err
);
    cmd_t                 cmd;
    logic [NUM_BANKS-1:0] bank_open;
    age_t                 wr_age [NUM_BANKS];
    age_t                 rd_age [NUM_BANKS];
    age_t                 hist_age [NUM_HIST];
    logic [NUM_HIST-1:0]  hist_load;
    logic                 cke_short;
    logic                 pd_exit;
    age_t                 srx_age;
    logic [NUM_RULES-1:0] viol_d;
    logic                 proto_d;

    ddr_cmd_decode u_decode (
        .sel_n  (sel_n),
        .rstb_n (rstb_n),
        .cstb_n (cstb_n),
        .wen_n  (wen_n),
        .clk_en (clk_en),
        .bsel_hi(bsel_hi),
        .bsel_lo(bsel_lo),
        .ap_bit (ap_bit),
        .cmd    (cmd)
    );

    ddr_bank_track #(.NB(NUM_BANKS)) u_banks (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .bank_open(bank_open),
        .wr_age   (wr_age),
        .rd_age   (rd_age)
    );

    ddr_pwr_track u_pwr (
        .clk      (clk),
        .rst      (rst),
        .clk_en   (clk_en),
        .sr_entry (cmd.sr_entry),
        .cke_short(cke_short),
        .pd_exit  (pd_exit),
        .srx_age  (srx_age)
    );

    assign hist_load[HIST_WR]  = cmd.valid && cmd.op == CMD_WR;
    assign hist_load[HIST_RD]  = cmd.valid && cmd.op == CMD_RD;
    assign hist_load[HIST_BST] = cmd.valid && cmd.op == CMD_BST;
    assign hist_load[HIST_MRS] = cmd.valid && cmd.op == CMD_MRS;

    for (genvar h = 0; h < NUM_HIST; h++) begin : g_hist
        ddr_age_ctr #(.W(AGE_W)) u_age (
            .clk (clk),
            .rst (rst),
            .load(hist_load[h]),
            .age (hist_age[h])
        );
    end

    age_t lim_wr2pre, lim_rd2pre, lim_wr2rd, lim_rd2wr, lim_bst2wr;

    always_comb begin
        lim_wr2pre = min_wr2pre(cfg_bl);
        lim_rd2pre = half_burst(cfg_bl);
        lim_wr2rd  = min_wr2rd(cfg_bl);
        lim_rd2wr  = min_rd2wr(cfg_bl, cfg_cl_half);
        lim_bst2wr = min_bst2wr(cfg_cl_half);
    end

    always_comb begin
        viol_d  = '0;
        proto_d = 1'b0;
        if (cmd.valid) begin
            case (cmd.op)
                CMD_ACT: begin
                    if (bank_open[cmd.bank])                 proto_d = 1'b1;
                    if (hist_age[HIST_MRS] < age_t'(MRS_MIN)) viol_d[RULE_MRS] = 1'b1;
                end
                CMD_RD: begin
                    if (!bank_open[cmd.bank])               proto_d = 1'b1;
                    if (hist_age[HIST_WR] < lim_wr2rd)      viol_d[RULE_WR2RD] = 1'b1;
                end
                CMD_WR: begin
                    if (!bank_open[cmd.bank])               proto_d = 1'b1;
                    if (hist_age[HIST_RD] < lim_rd2wr)      viol_d[RULE_RD2WR] = 1'b1;
                    if (hist_age[HIST_BST] < lim_bst2wr)    viol_d[RULE_BST2WR] = 1'b1;
                end
                CMD_PRE: begin
                    for (int b = 0; b < NUM_BANKS; b++) begin
                        if (cmd.ap || cmd.bank == BANK_W'(b)) begin
                            if (wr_age[b] < lim_wr2pre) viol_d[RULE_WR2PRE] = 1'b1;
                            if (rd_age[b] < lim_rd2pre) viol_d[RULE_RD2PRE] = 1'b1;
                        end
                    end
                end
                CMD_MRS: begin
                    if (hist_age[HIST_MRS] < age_t'(MRS_MIN)) viol_d[RULE_MRS] = 1'b1;
                end
                default: ;
            endcase

            if (cmd.op == CMD_RD) begin
                if (srx_age < age_t'(SRX_RD_MIN))  viol_d[RULE_SRX_RD] = 1'b1;
            end else begin
                if (srx_age < age_t'(SRX_CMD_MIN)) viol_d[RULE_SRX_CMD] = 1'b1;
            end

            if (pd_exit) viol_d[RULE_PD_EXIT] = 1'b1;
        end
        if (cke_short) viol_d[RULE_CKE_HOLD] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            viol      <= '0;
            proto_err <= 1'b0;
        end else begin
            viol      <= viol_d;
            proto_err <= proto_d;
        end
    end

    // R13
    flags_clear_after_reset_chk: assert property (@(posedge clk)
        rst |=> (viol == '0 && !proto_err));

    // R1
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(sel_n) |-> (viol[NUM_CMD_RULES-1:0] == '0 && !proto_err));

    // R6
    rd2pre_short_burst_chk: assert property (@(posedge clk) disable iff (rst)
        viol[RULE_RD2PRE] |-> ($past(cfg_bl) != 2'd0));

endmodule

// File: tb/ddr_cmd_timing_mon_bench.sv
module ddr_cmd_timing_mon_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 100000;

    localparam logic [2:0] K_ACT = 3'b011;
    localparam logic [2:0] K_RD  = 3'b101;
    localparam logic [2:0] K_WR  = 3'b100;
    localparam logic [2:0] K_PRE = 3'b010;
    localparam logic [2:0] K_REF = 3'b001;
    localparam logic [2:0] K_MRS = 3'b000;
    localparam logic [2:0] K_BST = 3'b110;
    localparam logic [2:0] K_NOP = 3'b111;

    logic       clk = 1'b0;
    logic       rst;
    logic       sel_n, rstb_n, cstb_n, wen_n, clk_en, bsel_hi, bsel_lo, ap_bit;
    logic [1:0] cfg_bl;
    logic       cfg_cl_half;
    logic [9:0] viol;
    logic       proto_err;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddr_cmd_timing_mon u_ddr_cmd_timing_mon (
        .clk(clk), .rst(rst), .sel_n(sel_n), .rstb_n(rstb_n), .cstb_n(cstb_n),
        .wen_n(wen_n), .clk_en(clk_en), .bsel_hi(bsel_hi), .bsel_lo(bsel_lo),
        .ap_bit(ap_bit), .cfg_bl(cfg_bl), .cfg_cl_half(cfg_cl_half),
        .viol(viol), .proto_err(proto_err)
    );

    typedef struct packed {
        logic       sel;
        logic [2:0] rcw;
        logic [1:0] bank;
        logic       ap;
        logic [9:0] ev;
        logic       ep;
        logic [3:0] req;
    } vec_t;

    // Burst length 4, CAS latency 3; one entry per cycle, clock enable high.
    localparam int NUM_VEC = 32;
    localparam vec_t TABLE [NUM_VEC] = '{
        '{1'b0, K_ACT, 2'b01, 1'b0, 10'h000, 1'b0, 4'd2},  // 0  R2 open bank 1
        '{1'b0, K_WR,  2'b01, 1'b0, 10'h000, 1'b0, 4'd2},  // 1  R2
        '{1'b0, K_NOP, 2'b00, 1'b0, 10'h000, 1'b0, 4'd1},  // 2
        '{1'b0, K_RD,  2'b01, 1'b0, 10'h004, 1'b0, 4'd7},  // 3  R7 d=2<4
        '{1'b0, K_NOP, 2'b00, 1'b0, 10'h000, 1'b0, 4'd1},  // 4
        '{1'b0, K_PRE, 2'b01, 1'b0, 10'h001, 1'b0, 4'd5},  // 5  R5 d=4<5, R6 d=2 ok
        '{1'b0, K_RD,  2'b01, 1'b0, 10'h000, 1'b1, 4'd4},  // 6  R4 closed bank
        '{1'b0, K_WR,  2'b10, 1'b0, 10'h008, 1'b1, 4'd8},  // 7  R8 d=1, R2 bank 2 closed
        '{1'b0, K_ACT, 2'b10, 1'b0, 10'h000, 1'b0, 4'd2},  // 8
        '{1'b0, K_ACT, 2'b10, 1'b0, 10'h000, 1'b1, 4'd4},  // 9  R4 already open
        '{1'b0, K_BST, 2'b00, 1'b0, 10'h000, 1'b0, 4'd9},  // 10
        '{1'b0, K_WR,  2'b10, 1'b0, 10'h010, 1'b0, 4'd9},  // 11 R9 d=1<2
        '{1'b0, K_NOP, 2'b00, 1'b0, 10'h000, 1'b0, 4'd1},  // 12
        '{1'b0, K_MRS, 2'b00, 1'b0, 10'h000, 1'b0, 4'd10}, // 13
        '{1'b0, K_ACT, 2'b00, 1'b0, 10'h020, 1'b0, 4'd10}, // 14 R10 d=1
        '{1'b0, K_NOP, 2'b00, 1'b0, 10'h000, 1'b0, 4'd1},  // 15
        '{1'b0, K_MRS, 2'b00, 1'b0, 10'h000, 1'b0, 4'd10}, // 16 R10 d=3
        '{1'b0, K_NOP, 2'b00, 1'b0, 10'h000, 1'b0, 4'd1},  // 17
        '{1'b0, K_MRS, 2'b00, 1'b0, 10'h000, 1'b0, 4'd10}, // 18 R10 d=2 boundary
        '{1'b1, K_ACT, 2'b00, 1'b0, 10'h000, 1'b0, 4'd1},  // 19 R1 deselected
        '{1'b0, K_PRE, 2'b01, 1'b1, 10'h000, 1'b0, 4'd3},  // 20 R3 all banks
        '{1'b0, K_RD,  2'b00, 1'b0, 10'h000, 1'b1, 4'd3},  // 21 R3 bank 0 closed
        '{1'b0, K_RD,  2'b10, 1'b0, 10'h000, 1'b1, 4'd3},  // 22 R3 bank 2 closed
        '{1'b0, K_ACT, 2'b11, 1'b0, 10'h000, 1'b0, 4'd2},  // 23
        '{1'b0, K_NOP, 2'b00, 1'b0, 10'h000, 1'b0, 4'd1},  // 24
        '{1'b0, K_NOP, 2'b00, 1'b0, 10'h000, 1'b0, 4'd1},  // 25
        '{1'b0, K_WR,  2'b11, 1'b1, 10'h000, 1'b0, 4'd8},  // 26 R8 d=4 boundary
        '{1'b0, K_WR,  2'b11, 1'b0, 10'h000, 1'b1, 4'd3},  // 27 R3 auto-precharged
        '{1'b0, K_ACT, 2'b01, 1'b0, 10'h000, 1'b0, 4'd2},  // 28
        '{1'b1, K_NOP, 2'b00, 1'b0, 10'h000, 1'b0, 4'd1},  // 29 R1
        '{1'b1, K_RD,  2'b10, 1'b0, 10'h000, 1'b0, 4'd1},  // 30 R1
        '{1'b0, K_RD,  2'b01, 1'b0, 10'h000, 1'b0, 4'd1}   // 31 R1 ages ran, d=4 ok
    };

    task automatic apply(input logic s, input logic [2:0] rcw, input logic [1:0] bk,
                         input logic ap, input logic ce);
        sel_n = s;
        {rstb_n, cstb_n, wen_n} = rcw;
        {bsel_hi, bsel_lo} = bk;
        ap_bit = ap;
        clk_en = ce;
    endtask

    task automatic check(input string tag, input logic [9:0] ev, input logic ep);
        checks++;
        if (viol !== ev || proto_err !== ep) begin
            fails++;
            $display("FAIL %s: viol=%h proto=%b expected viol=%h proto=%b",
                     tag, viol, proto_err, ev, ep);
        end
    endtask

    task automatic step(input logic s, input logic [2:0] rcw, input logic [1:0] bk,
                        input logic ap, input logic ce, input logic [9:0] ev,
                        input logic ep, input string tag);
        apply(s, rcw, bk, ap, ce);
        @(negedge clk);
        check(tag, ev, ep);
    endtask

    task automatic idle(input int n, input logic ce, input string tag);
        for (int k = 0; k < n; k++) step(1'b0, K_NOP, 2'b00, 1'b0, ce, 10'h000, 1'b0, tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        apply(1'b0, K_NOP, 2'b00, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R13 flags clear after reset", 10'h000, 1'b0);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run hung, actual still running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        cfg_bl = 2'd1;
        cfg_cl_half = 1'b0;
        @(negedge clk);
        do_reset();

        for (int i = 0; i < NUM_VEC; i++) begin
            vec_t e;
            e = TABLE[i];
            step(e.sel, e.rcw, e.bank, e.ap, 1'b1, e.ev, e.ep,
                 $sformatf("R%0d table[%0d]", e.req, i));
        end

        // R13: banks closed after reset
        do_reset();
        step(1'b0, K_RD, 2'b00, 1'b0, 1'b1, 10'h000, 1'b1, "R13 read after reset sees closed bank");

        // Burst length 8, CAS latency 3.5
        cfg_bl = 2'd2;
        cfg_cl_half = 1'b1;
        do_reset();
        step(1'b0, K_ACT, 2'b00, 1'b0, 1'b1, 10'h000, 1'b0, "R8 setup act");
        step(1'b0, K_RD,  2'b00, 1'b0, 1'b1, 10'h000, 1'b0, "R8 setup read");
        idle(5, 1'b1, "R8 gap");
        step(1'b0, K_WR,  2'b00, 1'b0, 1'b1, 10'h008, 1'b0, "R8 read-to-write d=6 < 7");
        idle(4, 1'b1, "R7 gap");
        step(1'b0, K_RD,  2'b00, 1'b0, 1'b1, 10'h004, 1'b0, "R7 write-to-read d=5 < 6");
        idle(2, 1'b1, "R6 gap");
        step(1'b0, K_PRE, 2'b00, 1'b0, 1'b1, 10'h002, 1'b0, "R6 read-to-precharge d=3 < 4");
        step(1'b0, K_ACT, 2'b01, 1'b0, 1'b1, 10'h000, 1'b0, "R5 setup act");
        idle(2, 1'b1, "R8 gap");
        step(1'b0, K_WR,  2'b01, 1'b0, 1'b1, 10'h000, 1'b0, "R8 read-to-write d=7 boundary");
        idle(5, 1'b1, "R5 gap");
        step(1'b0, K_PRE, 2'b01, 1'b0, 1'b1, 10'h001, 1'b0, "R5 write-to-precharge d=6 < 7");
        step(1'b0, K_ACT, 2'b01, 1'b0, 1'b1, 10'h000, 1'b0, "R5 reopen");
        step(1'b0, K_WR,  2'b01, 1'b0, 1'b1, 10'h000, 1'b0, "R5 write");
        idle(6, 1'b1, "R5 gap");
        step(1'b0, K_PRE, 2'b01, 1'b0, 1'b1, 10'h000, 1'b0, "R5 write-to-precharge d=7 boundary");
        step(1'b0, K_ACT, 2'b10, 1'b0, 1'b1, 10'h000, 1'b0, "R8 act bank 2");
        step(1'b0, K_RD,  2'b10, 1'b0, 1'b1, 10'h000, 1'b0, "R7 write-to-read d=9 ok");
        idle(6, 1'b1, "R8 gap");
        step(1'b0, K_WR,  2'b10, 1'b0, 1'b1, 10'h000, 1'b0, "R8 read-to-write d=7 ok");
        step(1'b0, K_BST, 2'b00, 1'b0, 1'b1, 10'h000, 1'b0, "R9 stop");
        idle(1, 1'b1, "R9 gap");
        step(1'b0, K_WR,  2'b10, 1'b0, 1'b1, 10'h010, 1'b0, "R9 stop-to-write d=2 < 3");
        step(1'b0, K_BST, 2'b00, 1'b0, 1'b1, 10'h000, 1'b0, "R9 stop");
        idle(2, 1'b1, "R9 gap");
        step(1'b0, K_WR,  2'b10, 1'b0, 1'b1, 10'h000, 1'b0, "R9 stop-to-write d=3 boundary");

        // Self-refresh exit windows
        cfg_bl = 2'd1;
        cfg_cl_half = 1'b0;
        do_reset();
        step(1'b0, K_ACT, 2'b00, 1'b0, 1'b1, 10'h000, 1'b0, "R11 setup act");
        step(1'b0, K_REF, 2'b00, 1'b0, 1'b0, 10'h000, 1'b0, "R11 self-refresh entry");
        idle(2, 1'b0, "R11 in self-refresh");
        step(1'b0, K_NOP, 2'b00, 1'b0, 1'b1, 10'h000, 1'b0, "R11 exit cycle");
        idle(4, 1'b1, "R11 gap");
        step(1'b0, K_RD,  2'b00, 1'b0, 1'b1, 10'h080, 1'b0, "R11 read d=5 < 200");
        step(1'b0, K_MRS, 2'b00, 1'b0, 1'b1, 10'h040, 1'b0, "R11 non-read d=6 < 10");
        idle(2, 1'b1, "R11 gap");
        step(1'b0, K_BST, 2'b00, 1'b0, 1'b1, 10'h040, 1'b0, "R11 non-read d=9 < 10");
        step(1'b0, K_ACT, 2'b01, 1'b0, 1'b1, 10'h000, 1'b0, "R11 non-read d=10 boundary");
        idle(188, 1'b1, "R11 long gap");
        step(1'b0, K_RD,  2'b00, 1'b0, 1'b1, 10'h080, 1'b0, "R11 read d=199 < 200");
        step(1'b0, K_RD,  2'b00, 1'b0, 1'b1, 10'h000, 1'b0, "R11 read d=200 boundary");

        // Power-down exit and clock-enable hold
        do_reset();
        idle(2, 1'b0, "R12 power-down");
        step(1'b0, K_ACT, 2'b10, 1'b0, 1'b1, 10'h200, 1'b0, "R12 command in exit cycle");
        step(1'b0, K_NOP, 2'b00, 1'b0, 1'b0, 10'h100, 1'b0, "R12 clock enable held one cycle");
        step(1'b0, K_NOP, 2'b00, 1'b0, 1'b0, 10'h000, 1'b0, "R12 low held");
        step(1'b0, K_NOP, 2'b00, 1'b0, 1'b1, 10'h000, 1'b0, "R12 exit without command");
        step(1'b0, K_ACT, 2'b00, 1'b0, 1'b1, 10'h000, 1'b0, "R12 command one cycle after exit");
        step(1'b0, K_NOP, 2'b00, 1'b0, 1'b1, 10'h000, 1'b0, "R13 flag lasts one cycle");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule